// File: doc/BRIEF.md
# Three-Shunt Phase Current Sampler

This block times the sampling of the three low-side shunt resistors of a three-phase inverter. It watches the up-down PWM carrier counter. When the counter reaches the carrier period it gives a single-clock ADC trigger. At that point the zero vector with every low-side switch on is always present, so each phase current flows through its own shunt. At the same edge the block takes a copy of the per-phase measurability mask from the voltage compensator.

When the ADC reports completion, the block turns the three 12-bit offset-binary codes into signed currents. It then uses the latched mask to build a full set of three phase currents. A phase flagged as not measurable is rebuilt from the other two, using the rule that the three currents sum to zero. If fewer than two phases are measurable, the block cannot rebuild the set. It keeps the previous currents and flags the period as unusable.

The control sequence is a three-state machine:
- `ST_IDLE` waits for the carrier peak.
- `ST_CONVERT` waits for the ADC done strobe.
- `ST_PUBLISH` lasts one clock and presents the result.

Transitions:
- IDLE→CONVERT on a peak hit.
- CONVERT→PUBLISH on ADC done.
- PUBLISH→IDLE by default.
- PUBLISH→CONVERT if a new peak arrives in that same cycle.

Top module: `shunt_sampler`

## Requirements
- R1: `adc_trig` is high for exactly one clock, in the cycle after a clock edge where `carrier_cnt` equals `carrier_period`. If the counter stays at the period value, no further pulse follows until it has left that value.
- R2: Each ADC code is converted to a signed current by subtracting 2048, so code 2048 reads as 0, code 0 as -2048 and code 4095 as +2047.
- R3: With mask `3'b111`, all three output currents are the offset-corrected ADC readings. Bit 0 of the mask is phase A, bit 1 is phase B, bit 2 is phase C, and a 1 means measurable.
- R4: With exactly one mask bit clear, that phase's output is the negative sum of the other two corrected readings. The other two phases are passed through directly.
- R5: A rebuilt current is saturated to the 13-bit signed range -4096..4095.
- R6: With fewer than two mask bits set, the published period keeps the previous three currents and raises `recon_err` together with `cur_valid`. `recon_err` keeps its value until the next publish.
- R7: The mask is captured at the peak edge that starts a conversion. Later mask changes have no effect on that conversion's result.
- R8: `cur_valid` is a one-clock pulse in the cycle after the clock edge that sees `adc_done` high while a conversion is pending.
- R9: An `adc_done` strobe that arrives while no conversion is pending is ignored. No valid pulse follows and the outputs keep their values.
- R10: After reset, `adc_trig`, `cur_valid` and `recon_err` are 0 and all three currents are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_cnt | input | 16 | Up-down PWM carrier counter value |
| carrier_period | input | 16 | Carrier peak value |
| meas_mask | input | 3 | Per-phase measurable flags (A=bit0) |
| adc_code_a | input | 12 | Offset-binary shunt reading, phase A |
| adc_code_b | input | 12 | Offset-binary shunt reading, phase B |
| adc_code_c | input | 12 | Offset-binary shunt reading, phase C |
| adc_done | input | 1 | ADC conversion complete strobe |
| adc_trig | output | 1 | One-clock sample trigger at the carrier peak |
| cur_a | output | 13 | Signed phase A current |
| cur_b | output | 13 | Signed phase B current |
| cur_c | output | 13 | Signed phase C current |
| cur_valid | output | 1 | One-clock result strobe |
| recon_err | output | 1 | Last published period lacked two measurable phases |

## Verification
The reconstruction is driven with the full mask, and with each single-phase mask in turn. The single-phase masks show that the rebuilt phase is the right one and that the sign of the sum is correct. The rail codes 0 and 4095 exercise the offset conversion. Two readings at code 0 with the third phase missing push the rebuilt value past +4095 and expose the saturation. Masks with two or three phases missing show that the earlier currents are kept and the error flag is raised. A mask change during conversion, a peak held for several cycles, and a done strobe with no pending conversion each separate correct latching and sequencing from an edge-sensitive but careless design.

// File: rtl/shunt_pkg.sv
package shunt_pkg;
    localparam int NPH = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_PUBLISH = 2'd2
    } samp_state_t;
endpackage

// File: rtl/shunt_peak.sv
module shunt_peak #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] carrier_cnt,
    input  logic [CNT_W-1:0] carrier_period,
    output logic             peak_hit,
    output logic             trig
);
    logic at_peak;
    logic at_peak_q;

    assign at_peak  = (carrier_cnt == carrier_period);
    assign peak_hit = at_peak && !at_peak_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            at_peak_q <= 1'b0;
            trig      <= 1'b0;
        end else begin
            at_peak_q <= at_peak;
            trig      <= peak_hit;
        end
    end

    // R1: the trigger never lasts longer than one clock
    assert_trig_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);
endmodule

// File: rtl/shunt_seq.sv
module shunt_seq
    import shunt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        peak_hit,
    input  logic        adc_done,
    output samp_state_t state_q,
    output logic        accept,
    output logic        capture
);
    samp_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (peak_hit) begin
                    accept  = 1'b1;
                    state_d = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (adc_done) begin
                    capture = 1'b1;
                    state_d = ST_PUBLISH;
                end
            end
            ST_PUBLISH: begin
                if (peak_hit) begin
                    accept  = 1'b1;
                    state_d = ST_CONVERT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R8: publish lasts a single cycle
    assert_publish_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |=> (state_q != ST_PUBLISH));
    // R8: publish is only reached through a done strobe
    assert_publish_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |-> $past(adc_done));
endmodule

// File: rtl/shunt_rebuild.sv
module shunt_rebuild
    import shunt_pkg::*;
#(
    parameter int ADC_W = 12,
    parameter int OUT_W = ADC_W + 1
) (
    input  logic [NPH*ADC_W-1:0] codes,
    input  logic [NPH-1:0]       mask,
    output logic [NPH*OUT_W-1:0] currents,
    output logic                 usable
);
    localparam int SUM_W = OUT_W + 2;
    localparam logic signed [OUT_W-1:0] OFF_S = OUT_W'(1 << (ADC_W - 1));
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] MIN_S = -SUM_W'(1 << (OUT_W - 1));

    logic signed [OUT_W-1:0] meas [NPH];

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        localparam int J = (p + 1) % NPH;
        localparam int K = (p + 2) % NPH;
        logic signed [SUM_W-1:0] neg_sum;
        logic signed [OUT_W-1:0] rebuilt;

        assign meas[p] = $signed({1'b0, codes[p*ADC_W +: ADC_W]}) - OFF_S;

        assign neg_sum = -(SUM_W'(meas[J]) + SUM_W'(meas[K]));

        always_comb begin
            if (neg_sum > MAX_S)      rebuilt = MAX_S[OUT_W-1:0];
            else if (neg_sum < MIN_S) rebuilt = MIN_S[OUT_W-1:0];
            else                      rebuilt = neg_sum[OUT_W-1:0];
        end

        assign currents[p*OUT_W +: OUT_W] = mask[p] ? meas[p] : rebuilt;
    end

    assign usable = (mask[0] & mask[1]) | (mask[1] & mask[2]) | (mask[0] & mask[2]);
endmodule

// File: rtl/shunt_sampler.sv
module shunt_sampler
    import shunt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ADC_W = 12,
    parameter int OUT_W = ADC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        carrier_cnt,
    input  logic [CNT_W-1:0]        carrier_period,
    input  logic [2:0]              meas_mask,
    input  logic [ADC_W-1:0]        adc_code_a,
    input  logic [ADC_W-1:0]        adc_code_b,
    input  logic [ADC_W-1:0]        adc_code_c,
    input  logic                    adc_done,
    output logic                    adc_trig,
    output logic signed [OUT_W-1:0] cur_a,
    output logic signed [OUT_W-1:0] cur_b,
    output logic signed [OUT_W-1:0] cur_c,
    output logic                    cur_valid,
    output logic                    recon_err
);
    samp_state_t          state_q;
    logic                 peak_hit;
    logic                 accept;
    logic                 capture;
    logic [NPH-1:0]       mask_q;
    logic [NPH*OUT_W-1:0] rebuilt;
    logic                 usable;

    shunt_peak #(.CNT_W(CNT_W)) u_peak (
        .clk            (clk),
        .rst_n          (rst_n),
        .carrier_cnt    (carrier_cnt),
        .carrier_period (carrier_period),
        .peak_hit       (peak_hit),
        .trig           (adc_trig)
    );

    shunt_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .peak_hit (peak_hit),
        .adc_done (adc_done),
        .state_q  (state_q),
        .accept   (accept),
        .capture  (capture)
    );

    shunt_rebuild #(.ADC_W(ADC_W), .OUT_W(OUT_W)) u_rebuild (
        .codes    ({adc_code_c, adc_code_b, adc_code_a}),
        .mask     (mask_q),
        .currents (rebuilt),
        .usable   (usable)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            cur_a     <= '0;
            cur_b     <= '0;
            cur_c     <= '0;
            recon_err <= 1'b0;
        end else begin
            if (accept) mask_q <= meas_mask;
            if (capture) begin
                recon_err <= !usable;
                if (usable) begin
                    cur_a <= rebuilt[0*OUT_W +: OUT_W];
                    cur_b <= rebuilt[1*OUT_W +: OUT_W];
                    cur_c <= rebuilt[2*OUT_W +: OUT_W];
                end
            end
        end
    end

    assign cur_valid = (state_q == ST_PUBLISH);

    // R7: latched mask is frozen while a conversion is pending
    assert_mask_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && $past(state_q) == ST_CONVERT) |-> $stable(mask_q));
    // R6: an unusable period leaves the currents untouched
    assert_hold_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && recon_err) |-> ($stable(cur_a) && $stable(cur_b) && $stable(cur_c)));
    // R9: outputs move only at a publish
    assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_valid |-> ($stable(cur_a) && $stable(recon_err)));
endmodule

// File: tb/test_shunt_sampler.sv
module test_shunt_sampler;
    localparam int PERIOD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] carrier_cnt = '0;
    logic [15:0] carrier_period = 16'(PERIOD);
    logic [2:0]  meas_mask = 3'b111;
    logic [11:0] adc_code_a = '0, adc_code_b = '0, adc_code_c = '0;
    logic        adc_done = 1'b0;
    logic        adc_trig, cur_valid, recon_err;
    logic signed [12:0] cur_a, cur_b, cur_c;

    int n_cmp = 0;
    int n_bad = 0;
    int ea = 0, eb = 0, ec = 0;

    always #10 clk = ~clk;

    shunt_sampler i_shunt_sampler (
        .clk(clk), .rst_n(rst_n), .carrier_cnt(carrier_cnt),
        .carrier_period(carrier_period), .meas_mask(meas_mask),
        .adc_code_a(adc_code_a), .adc_code_b(adc_code_b), .adc_code_c(adc_code_c),
        .adc_done(adc_done), .adc_trig(adc_trig), .cur_a(cur_a), .cur_b(cur_b),
        .cur_c(cur_c), .cur_valid(cur_valid), .recon_err(recon_err)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clamp13(input int v);
        if (v > 4095) return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    // raise carrier to peak for one cycle; checks trigger pulse
    task automatic hit_peak(input logic [2:0] m);
        @(negedge clk);
        meas_mask = m;
        carrier_cnt = 16'(PERIOD);
        @(posedge clk);
        @(negedge clk);
        chk(int'(adc_trig), 1, "R1 trigger after peak");
        carrier_cnt = 16'(PERIOD - 1);
    endtask

    // deliver ADC results; on return valid cycle is being sampled
    task automatic convert(input int a, input int b, input int c);
        adc_code_a = 12'(a); adc_code_b = 12'(b); adc_code_c = 12'(c);
        adc_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    task automatic expect_set(input logic [2:0] m, input int a, input int b, input int c,
                              input string tag);
        int xa = a - 2048, xb = b - 2048, xc = c - 2048;
        int cnt = int'(m[0]) + int'(m[1]) + int'(m[2]);
        chk(int'(cur_valid), 1, {tag, " valid"});
        if (cnt >= 2) begin
            ea = m[0] ? xa : clamp13(-(xb + xc));
            eb = m[1] ? xb : clamp13(-(xa + xc));
            ec = m[2] ? xc : clamp13(-(xa + xb));
        end
        chk(int'(recon_err), (cnt < 2) ? 1 : 0, {tag, " err"});
        chk(int'(cur_a), ea, {tag, " A"});
        chk(int'(cur_b), eb, {tag, " B"});
        chk(int'(cur_c), ec, {tag, " C"});
    endtask

    task automatic t_reset;
        chk(int'(adc_trig), 0, "R10 trig");
        chk(int'(cur_valid), 0, "R10 valid");
        chk(int'(recon_err), 0, "R10 err");
        chk(int'(cur_a) | int'(cur_b) | int'(cur_c), 0, "R10 currents");
    endtask

    task automatic t_direct;
        hit_peak(3'b111);
        convert(2148, 1948, 2048);
        expect_set(3'b111, 2148, 1948, 2048, "R3 direct");
        hit_peak(3'b111);
        convert(0, 4095, 2048);
        expect_set(3'b111, 0, 4095, 2048, "R2 rail codes");
    endtask

    task automatic t_one_missing;
        hit_peak(3'b110);
        convert(4000, 2300, 1500);
        expect_set(3'b110, 4000, 2300, 1500, "R4 A rebuilt");
        hit_peak(3'b101);
        convert(1000, 4000, 3000);
        expect_set(3'b101, 1000, 4000, 3000, "R4 B rebuilt");
        hit_peak(3'b011);
        convert(2500, 1200, 0);
        expect_set(3'b011, 2500, 1200, 0, "R4 C rebuilt");
    endtask

    task automatic t_saturate;
        hit_peak(3'b011);
        convert(0, 0, 100);
        expect_set(3'b011, 0, 0, 100, "R5 saturate");
        chk(int'(cur_c), 4095, "R5 clamp value");
    endtask

    task automatic t_two_missing;
        hit_peak(3'b100);
        convert(111, 222, 333);
        expect_set(3'b100, 111, 222, 333, "R6 hold");
        @(posedge clk); @(negedge clk);
        chk(int'(recon_err), 1, "R6 err held");
        hit_peak(3'b000);
        convert(3000, 3000, 3000);
        expect_set(3'b000, 3000, 3000, 3000, "R6 none");
        hit_peak(3'b111);
        convert(2058, 2038, 2048);
        expect_set(3'b111, 2058, 2038, 2048, "R6 recover");
    endtask

    task automatic t_mask_change;
        hit_peak(3'b111);
        @(negedge clk); meas_mask = 3'b001;
        @(negedge clk);
        convert(2100, 2000, 2010);
        expect_set(3'b111, 2100, 2000, 2010, "R7 late mask");
    endtask

    task automatic t_held_peak;
        @(negedge clk);
        meas_mask = 3'b111;
        carrier_cnt = 16'(PERIOD);
        @(posedge clk); @(negedge clk);
        chk(int'(adc_trig), 1, "R1 first");
        @(posedge clk); @(negedge clk);
        chk(int'(adc_trig), 0, "R1 held no repeat");
        @(posedge clk); @(negedge clk);
        chk(int'(adc_trig), 0, "R1 held no repeat 2");
        carrier_cnt = 16'(PERIOD - 1);
        convert(2049, 2047, 2048);
        expect_set(3'b111, 2049, 2047, 2048, "R1 period");
    endtask

    task automatic t_valid_width;
        hit_peak(3'b111);
        @(negedge clk);
        chk(int'(cur_valid), 0, "R8 no early valid");
        convert(2060, 2040, 2048);
        expect_set(3'b111, 2060, 2040, 2048, "R8 timing");
        @(posedge clk); @(negedge clk);
        chk(int'(cur_valid), 0, "R8 single cycle");
    endtask

    task automatic t_stray_done;
        @(negedge clk);
        convert(4000, 100, 50);
        chk(int'(cur_valid), 0, "R9 no valid");
        chk(int'(cur_a), ea, "R9 A kept");
        chk(int'(cur_b), eb, "R9 B kept");
        chk(int'(recon_err), 0, "R9 err kept");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_one_missing();
        t_saturate();
        t_two_missing();
        t_mask_change();
        t_held_peak();
        t_valid_width();
        t_stray_done();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule